// File: doc/BRIEF.md
# Prefixed Bit and Shift Unit

This unit executes the second-byte operations of the bit-manipulation opcode group of an 8-bit processor: rotates and shifts, single-bit tests, and single-bit clears and sets. Each cycle it can accept one operation, described by the opcode byte, the operand byte already fetched from a register or from memory, and the current carry flag. One cycle later it presents the result byte, the carry, zero and sign flags, and the write-back plan. That plan says whether the memory byte, a register, or both must be updated, and which register.

The opcode is decoded in three fields. The top two bits choose the class. The middle three bits choose either the shift operation or the bit number. The low three bits name the register operand, and code 6 means the memory byte addressed through the pointer register. In the indexed form the operand is always the memory byte. The result is stored back to memory, and when the register field is not 6 it is also copied into the register that the field names. Memory timing, instruction fetch and the remaining flags belong to the surrounding core.

Top module: `cb_bitshift_unit`

## Requirements
- R1: Opcode bits 7:6 choose the class (00 shift/rotate, 01 test bit, 10 clear bit, 11 set bit); bits 5:3 hold the shift selector or the bit number b; bits 2:0 hold the register code (B=0, C=1, D=2, E=3, H=4, L=5, memory=6, A=7).
- R2: Shift selector 0 rotates left and selector 1 rotates right; the bit that leaves the byte goes both to carry_out and to the opposite end of the byte.
- R3: Selector 2 rotates left through the carry and selector 3 rotates right through the carry: carry_in enters the vacated end and the bit that leaves goes to carry_out.
- R4: Selector 4 and selector 6 both shift left, fill bit 0 with zero, and send bit 7 to carry_out.
- R5: Selector 5 shifts right and keeps bit 7; selector 7 shifts right and fills bit 7 with zero; in both, bit 0 goes to carry_out.
- R6: For the shift class, flag_upd is 1, zero_out is 1 exactly when the result is 0, and sign_out equals result bit 7.
- R7: A bit test returns the operand unchanged, sets zero_out to the inverse of operand bit b, sets sign_out only when b is 7 and bit 7 is 1, passes carry_in to carry_out, sets flag_upd, and raises neither write enable.
- R8: Clear-bit and set-bit force bit b to 0 or 1 and leave the other bits unchanged; flag_upd is 0, carry_out equals carry_in, and zero_out and sign_out describe the result.
- R9: In the plain form, register code 6 raises mem_we only; any other code raises reg_we only, with reg_sel equal to the code.
- R10: In the indexed form, every class except the bit test raises mem_we, and reg_we is also raised with reg_sel equal to the code when the code is not 6.
- R11: Outputs appear one cycle after valid_in; a cycle without valid_in gives valid_out, mem_we and reg_we of 0 in the next cycle; reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | An operation is presented this cycle |
| opcode | input | 8 | Second opcode byte |
| operand | input | 8 | Operand byte |
| carry_in | input | 1 | Current carry flag |
| indexed | input | 1 | Operation uses the indexed memory form |
| valid_out | output | 1 | Result outputs are valid |
| result | output | 8 | Result byte |
| carry_out | output | 1 | New carry flag |
| zero_out | output | 1 | New zero flag |
| sign_out | output | 1 | New sign flag |
| flag_upd | output | 1 | Flags must be written back |
| mem_we | output | 1 | Write the result to the memory byte |
| reg_we | output | 1 | Write the result to register reg_sel |
| reg_sel | output | 3 | Register code for write-back |

## Verification
On every cycle the assertions check the one-cycle handshake. They also check that a bit test never writes and returns its operand, that the arithmetic right shift keeps the sign bit, that the indexed form always stores to memory, and that the plain form never writes both destinations. The exact results and carries of every shift selector, the flag values and the register codes chosen can only be shown by the bench scenarios. Those scenarios compare each operation against a separately written model, with directed edge operands such as 0x80, 0x01 and 0x81 and with random traffic.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    localparam int DATA_W  = 8;
    localparam int FIELD_W = 3;
    localparam logic [FIELD_W-1:0] REG_MEM = 3'd6;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_TEST  = 2'b01,
        CLS_CLR   = 2'b10,
        CLS_SET   = 2'b11
    } op_class_e;

    typedef enum logic [2:0] {
        SH_ROL   = 3'd0,
        SH_ROR   = 3'd1,
        SH_RLC   = 3'd2,
        SH_RRC   = 3'd3,
        SH_ASL   = 3'd4,
        SH_ASR   = 3'd5,
        SH_LSL   = 3'd6,
        SH_LSR   = 3'd7
    } shift_sel_e;

    typedef struct packed {
        op_class_e          cls;
        logic [FIELD_W-1:0] mid;
        logic [FIELD_W-1:0] rcode;
    } op_fields_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              carry;
        logic              zero;
        logic              sign;
        logic              upd;
    } alu_out_t;

    function automatic op_fields_t split_opcode(input logic [7:0] op);
        op_fields_t f;
        f.cls   = op_class_e'(op[7:6]);
        f.mid   = op[5:3];
        f.rcode = op[2:0];
        return f;
    endfunction

endpackage

// File: rtl/cbu_shifter.sv
module cbu_shifter
    import cbu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [FIELD_W-1:0] sel,
    input  logic [W-1:0]       din,
    input  logic               cin,
    output logic [W-1:0]       dout,
    output logic               cout
);
    always_comb begin
        dout = din;
        cout = cin;
        unique case (shift_sel_e'(sel))
            SH_ROL: begin dout = {din[W-2:0], din[W-1]}; cout = din[W-1]; end
            SH_ROR: begin dout = {din[0], din[W-1:1]};   cout = din[0];   end
            SH_RLC: begin dout = {din[W-2:0], cin};      cout = din[W-1]; end
            SH_RRC: begin dout = {cin, din[W-1:1]};      cout = din[0];   end
            SH_ASL,
            SH_LSL: begin dout = {din[W-2:0], 1'b0};     cout = din[W-1]; end
            SH_ASR: begin dout = {din[W-1], din[W-1:1]}; cout = din[0];   end
            SH_LSR: begin dout = {1'b0, din[W-1:1]};     cout = din[0];   end
            default: begin dout = din; cout = cin; end
        endcase
    end
endmodule

// File: rtl/cbu_bitop.sv
module cbu_bitop
    import cbu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_class_e          cls,
    input  logic [FIELD_W-1:0] idx,
    input  logic [W-1:0]       din,
    output logic [W-1:0]       dout,
    output logic               tested
);
    logic [W-1:0] mask;

    generate
        for (genvar i = 0; i < W; i++) begin : g_mask
            assign mask[i] = (idx == FIELD_W'(i));
        end
    endgenerate

    assign tested = |(din & mask);

    always_comb begin
        unique case (cls)
            CLS_CLR: dout = din & ~mask;
            CLS_SET: dout = din | mask;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/cbu_writeback.sv
module cbu_writeback
    import cbu_pkg::*;
(
    input  op_class_e          cls,
    input  logic [FIELD_W-1:0] rcode,
    input  logic               indexed,
    output logic               mem_we,
    output logic               reg_we
);
    logic is_test, is_mem;
    assign is_test = (cls == CLS_TEST);
    assign is_mem  = (rcode == REG_MEM);

    always_comb begin
        if (is_test) begin
            mem_we = 1'b0;
            reg_we = 1'b0;
        end else if (indexed) begin
            mem_we = 1'b1;
            reg_we = !is_mem;
        end else begin
            mem_we = is_mem;
            reg_we = !is_mem;
        end
    end
endmodule

// File: rtl/cb_bitshift_unit.sv
module cb_bitshift_unit
    import cbu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_in,
    input  logic [7:0]         opcode,
    input  logic [DATA_W-1:0]  operand,
    input  logic               carry_in,
    input  logic               indexed,
    output logic               valid_out,
    output logic [DATA_W-1:0]  result,
    output logic               carry_out,
    output logic               zero_out,
    output logic               sign_out,
    output logic               flag_upd,
    output logic               mem_we,
    output logic               reg_we,
    output logic [FIELD_W-1:0] reg_sel
);
    localparam logic [FIELD_W-1:0] TOP_IDX = FIELD_W'(DATA_W - 1);

    op_fields_t        f;
    logic [DATA_W-1:0] sh_data, bo_data;
    logic              sh_carry, bo_tested;
    logic              wb_mem, wb_reg;
    alu_out_t          nxt;

    assign f = split_opcode(opcode);

    cbu_shifter #(.W(DATA_W)) u_shift (
        .sel(f.mid), .din(operand), .cin(carry_in),
        .dout(sh_data), .cout(sh_carry)
    );

    cbu_bitop #(.W(DATA_W)) u_bit (
        .cls(f.cls), .idx(f.mid), .din(operand),
        .dout(bo_data), .tested(bo_tested)
    );

    cbu_writeback u_wb (
        .cls(f.cls), .rcode(f.rcode), .indexed(indexed),
        .mem_we(wb_mem), .reg_we(wb_reg)
    );

    always_comb begin
        unique case (f.cls)
            CLS_SHIFT: begin
                nxt.data  = sh_data;
                nxt.carry = sh_carry;
                nxt.zero  = (sh_data == '0);
                nxt.sign  = sh_data[DATA_W-1];
                nxt.upd   = 1'b1;
            end
            CLS_TEST: begin
                nxt.data  = operand;
                nxt.carry = carry_in;
                nxt.zero  = !bo_tested;
                nxt.sign  = (f.mid == TOP_IDX) && bo_tested;
                nxt.upd   = 1'b1;
            end
            default: begin
                nxt.data  = bo_data;
                nxt.carry = carry_in;
                nxt.zero  = (bo_data == '0);
                nxt.sign  = bo_data[DATA_W-1];
                nxt.upd   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            result    <= '0;
            carry_out <= 1'b0;
            zero_out  <= 1'b0;
            sign_out  <= 1'b0;
            flag_upd  <= 1'b0;
            mem_we    <= 1'b0;
            reg_we    <= 1'b0;
            reg_sel   <= '0;
        end else begin
            valid_out <= valid_in;
            mem_we    <= valid_in && wb_mem;
            reg_we    <= valid_in && wb_reg;
            if (valid_in) begin
                result    <= nxt.data;
                carry_out <= nxt.carry;
                zero_out  <= nxt.zero;
                sign_out  <= nxt.sign;
                flag_upd  <= nxt.upd;
                reg_sel   <= f.rcode;
            end
        end
    end

    // R11: one-cycle handshake
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    a_r11_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> (!valid_out && !mem_we && !reg_we));
    // R7: bit test writes nothing and returns its operand
    a_r7_test_no_write: assert property (@(posedge clk) disable iff (rst)
        (valid_in && opcode[7:6] == 2'b01) |=> (!mem_we && !reg_we && result == $past(operand)));
    // R5: arithmetic right shift keeps the sign bit
    a_r5_asr_sign: assert property (@(posedge clk) disable iff (rst)
        (valid_in && opcode[7:3] == 5'b00101) |=> (result[DATA_W-1] == $past(operand[DATA_W-1])));
    // R10: indexed non-test always stores to memory
    a_r10_indexed_mem: assert property (@(posedge clk) disable iff (rst)
        (valid_in && indexed && opcode[7:6] != 2'b01) |=> mem_we);
    // R9: plain form never writes both destinations
    a_r9_single_dest: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !indexed) |=> !(mem_we && reg_we));
endmodule

// File: tb/sim_cb_bitshift_unit.sv
module sim_cb_bitshift_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       valid_in, carry_in, indexed;
    logic [7:0] opcode, operand;
    logic       valid_out, carry_out, zero_out, sign_out, flag_upd, mem_we, reg_we;
    logic [7:0] result;
    logic [2:0] reg_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cb_bitshift_unit u0 (
        .clk(clk), .rst(rst), .valid_in(valid_in), .opcode(opcode),
        .operand(operand), .carry_in(carry_in), .indexed(indexed),
        .valid_out(valid_out), .result(result), .carry_out(carry_out),
        .zero_out(zero_out), .sign_out(sign_out), .flag_upd(flag_upd),
        .mem_we(mem_we), .reg_we(reg_we), .reg_sel(reg_sel)
    );

    // packed expectation: {valid, result, c, z, s, upd, mem, reg, sel} = 1+8+4+2+3 = 18 bits
    function automatic logic [17:0] model(input logic [7:0] op, input logic [7:0] d,
                                          input logic ci, input logic ix);
        logic [7:0] r; logic c, z, s, u, m, w;
        int b;
        b = int'(op[5:3]);
        r = d; c = ci; u = 1'b0; m = 1'b0; w = 1'b0;
        case (op[7:6])
            2'b00: begin
                u = 1'b1;
                case (op[5:3])
                    3'd0: begin c = d[7]; r = (d << 1) | {7'd0, d[7]}; end       // R2
                    3'd1: begin c = d[0]; r = (d >> 1) | {d[0], 7'd0}; end       // R2
                    3'd2: begin c = d[7]; r = (d << 1) | {7'd0, ci}; end         // R3
                    3'd3: begin c = d[0]; r = (d >> 1) | {ci, 7'd0}; end         // R3
                    3'd4, 3'd6: begin c = d[7]; r = d << 1; end                  // R4
                    3'd5: begin c = d[0]; r = (d >> 1) | (d & 8'h80); end        // R5
                    default: begin c = d[0]; r = d >> 1; end                     // R5
                endcase
                z = (r == 8'd0); s = r[7];                                       // R6
            end
            2'b01: begin
                u = 1'b1; z = !d[b]; s = (b == 7) && d[7];                       // R7
            end
            default: begin
                if (op[7:6] == 2'b10) r[b] = 1'b0; else r[b] = 1'b1;             // R8
                z = (r == 8'd0); s = r[7];
            end
        endcase
        if (op[7:6] != 2'b01) begin
            m = ix || (op[2:0] == 3'd6);                                         // R9 R10
            w = (op[2:0] != 3'd6);
        end
        return {1'b1, r, c, z, s, u, m, w, op[2:0]};
    endfunction

    function automatic string tag_of(input logic [7:0] op, input logic ix);
        if (ix && op[7:6] != 2'b01) return "R10";
        case (op[7:6])
            2'b01: return "R7";
            2'b10, 2'b11: return "R8";
            default: case (op[5:3])
                3'd0, 3'd1: return "R2";
                3'd2, 3'd3: return "R3";
                3'd4, 3'd6: return "R4";
                default: return "R5";
            endcase
        endcase
    endfunction

    task automatic compare(input logic [17:0] exp, input string tag);
        logic [17:0] act;
        act = {valid_out, result, carry_out, zero_out, sign_out, flag_upd, mem_we, reg_we, reg_sel};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (op=%h d=%h)", tag, act, exp, opcode, operand);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [7:0] d, input logic ci, input logic ix);
        logic [17:0] exp;
        exp = model(op, d, ci, ix);
        valid_in = 1'b1; opcode = op; operand = d; carry_in = ci; indexed = ix;
        @(posedge clk); @(negedge clk);
        compare(exp, tag_of(op, ix));   // R1 R6 R11: decode, flags, one-cycle latency
        valid_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; valid_in = 1'b0; opcode = 8'h00; operand = 8'h00;
        carry_in = 1'b0; indexed = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(18'd0, "R11 reset");
        rst = 1'b0;
        // R2 rotates
        run_op(8'h00, 8'h80, 1'b0, 1'b0);
        run_op(8'h09, 8'h01, 1'b0, 1'b0);
        // R3 through carry
        run_op(8'h12, 8'h40, 1'b1, 1'b0);
        run_op(8'h1B, 8'h01, 1'b0, 1'b0);
        // R4 left shifts, selector 6 equals selector 4
        run_op(8'h24, 8'h80, 1'b1, 1'b0);
        run_op(8'h37, 8'h80, 1'b1, 1'b0);
        run_op(8'h30, 8'hC3, 1'b0, 1'b0);
        // R5 right shifts
        run_op(8'h2D, 8'h81, 1'b0, 1'b0);
        run_op(8'h3F, 8'h81, 1'b1, 1'b0);
        // R7 bit tests
        run_op(8'h7E, 8'h80, 1'b1, 1'b0);
        run_op(8'h47, 8'hFE, 1'b0, 1'b1);
        // R8 clear and set
        run_op(8'hB8, 8'hFF, 1'b1, 1'b0);
        run_op(8'hC6, 8'h00, 1'b0, 1'b0);
        run_op(8'h80, 8'h01, 1'b0, 1'b0);
        // R9 / R10 write-back
        run_op(8'h06, 8'h55, 1'b0, 1'b1);
        run_op(8'h02, 8'h55, 1'b0, 1'b1);
        run_op(8'hCD, 8'h10, 1'b0, 1'b1);
        // R11 idle cycle: no valid, no writes
        @(posedge clk); @(negedge clk);
        checks++;
        if (valid_out || mem_we || reg_we) begin
            errors++;
            $display("FAIL R11: actual v=%b m=%b r=%b expected 000", valid_out, mem_we, reg_we);
        end
        // random traffic
        void'($urandom(32'h5EED));
        for (int i = 0; i < 400; i++) begin
            run_op(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 4) == 0) begin @(posedge clk); @(negedge clk); end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule